// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks the coherence state of every line in one private cache that sits on a shared snooping bus with write-invalidate semantics. It looks up local processor reads and writes in a small direct-mapped tag array. It decides whether each access can complete locally. When it cannot, it requests the bus for a read, a read-for-ownership, an address-only invalidate, or a writeback of a dirty victim. It also watches the transactions that other caches place on the bus. It answers with a "shared" indication when it holds the line. It signals that it will supply the data when it holds the line dirty.

Each line is Invalid, Shared, Exclusive or Modified. A read miss fills Exclusive when no other cache reports a copy and Shared when one does. A write to an Exclusive line therefore becomes Modified silently. A snooped read demotes Exclusive or Modified copies to Shared. A snooped read-for-ownership or invalidate removes the local copy. The data array, the bus arbiter and memory are outside the block: a grant input stands in for arbitration.

The line index is the low bits of the line address and the tag is the rest. A request is accepted in the cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Completion is a one-cycle `cpu_resp_valid` pulse. A bus transaction takes effect in a cycle where `bus_req_valid` and `bus_grant` are high and no snoop is present.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No bus request is pending, `cpu_req_ready` is high, and a snoop to any address sees `snoop_shared` low.
- R2: A read miss requests op code 1 (read) at the request address. If `bus_shared_in` is low in the granted cycle the line fills Exclusive; if it is high the line fills Shared.
- R3: A write to an Exclusive or Modified line completes with `cpu_resp_valid` in the cycle after acceptance. It produces no bus transaction, and the line ends Modified.
- R4: A write to a Shared line requests op code 3 (address-only invalidate) at the request address and leaves the line Modified once granted.
- R5: A write miss requests op code 2 (read-for-ownership) and fills the line Modified.
- R6: A snooped read (op 1) that hits a valid line raises `snoop_shared` in the same cycle. If the line is Modified it also raises `snoop_supply`. An Exclusive or Modified line becomes Shared.
- R7: A snooped op 2 or op 3 that hits makes the line Invalid, so the next local read requests op 1. `snoop_supply` is raised for op 2 on a Modified line and never for op 3.
- R8: While `snoop_valid` is high, `cpu_req_ready` is low and a `bus_grant` is ignored. The pending transaction is performed only in a later cycle without a snoop.
- R9: If a pending invalidate for a Shared line loses the race and another cache's op 2 or op 3 to that line is snooped, the pending request changes to op 2 on the next cycle.
- R10: A miss whose indexed line is Modified with a different tag first requests op 4 (writeback) at the victim address. The line becomes Invalid, and then the fill for the new address follows.
- R11: `snoop_shared` is raised only for a snooped address whose line is valid with a matching tag, whether the line is Shared, Exclusive or Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_resp_valid | output | 1 | One-cycle pulse when a request completes |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_op | output | 3 | 1 read, 2 read-for-ownership, 3 invalidate, 4 writeback |
| bus_req_addr | output | ADDR_W | Address of the requested transaction |
| bus_grant | input | 1 | Bus granted this cycle |
| bus_shared_in | input | 1 | Another cache holds the line being read |
| snoop_valid | input | 1 | Another cache's transaction is on the bus |
| snoop_op | input | 3 | Op code of the snooped transaction |
| snoop_addr | input | ADDR_W | Address of the snooped transaction |
| snoop_shared | output | 1 | Local valid copy of the snooped line exists |
| snoop_supply | output | 1 | Local dirty copy will supply data |

## Verification
Two kinds of event can meet in one cycle: a local bus transaction that is ready to be granted, and a snooped transaction from another cache. The bench provokes this in two ways. In the first, it raises the grant in the very cycle a snoop to an unrelated line is present; the scoreboard expects the pending read to appear exactly once, in the following snoop-free cycle. In the second, it holds back the grant while a pending invalidate meets a snooped invalidate to the same line. It then judges that the request turns into a read-for-ownership and that this, not the invalidate, is the transaction finally granted.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RD   = 3'd1,
    OP_RDX  = 3'd2,
    OP_UPGR = 3'd3,
    OP_WB   = 3'd4
  } bus_op_t;

  // Bus work a local access needs, given the indexed line's state and tag compare.
  function automatic bus_op_t need_op(input mesi_t st, input logic tag_eq, input logic wr);
    logic present;
    present = (st != ST_I) && tag_eq;
    if (present) begin
      if (wr && st == ST_S) return OP_UPGR;
      return OP_NONE;
    end
    if (st == ST_M) return OP_WB;
    return wr ? OP_RDX : OP_RD;
  endfunction

  // Next state of a line hit by another cache's transaction.
  function automatic mesi_t snoop_next(input mesi_t st, input bus_op_t op);
    case (op)
      OP_RD:         return (st == ST_I) ? ST_I : ST_S;
      OP_RDX, OP_UPGR: return ST_I;
      default:       return st;
    endcase
  endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int TAG_W  = 6,
  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snp_we,
  input  logic [IDX_W-1:0]             snp_idx,
  input  mesi_t                        snp_st,
  input  logic                         loc_we,
  input  logic [IDX_W-1:0]             loc_idx,
  input  mesi_t                        loc_st,
  input  logic [TAG_W-1:0]             loc_tag,
  output mesi_t [NLINES-1:0]           line_st,
  output logic  [NLINES-1:0][TAG_W-1:0] line_tag
);

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_st[i]  <= ST_I;
        line_tag[i] <= '0;
      end else if (snp_we && snp_idx == IDX_W'(i)) begin
        line_st[i] <= snp_st;
      end else if (loc_we && loc_idx == IDX_W'(i)) begin
        line_st[i]  <= loc_st;
        line_tag[i] <= loc_tag;
      end
    end
  end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snoop_valid,
  input  bus_op_t          snoop_op,
  input  logic [TAG_W-1:0] snoop_tag,
  input  mesi_t            cur_st,
  input  logic [TAG_W-1:0] cur_tag,
  output logic             snp_hit,
  output logic             snp_supply,
  output logic             snp_we,
  output mesi_t            snp_st
);

  assign snp_hit    = snoop_valid && (cur_st != ST_I) && (cur_tag == snoop_tag);
  assign snp_supply = snp_hit && (cur_st == ST_M) && (snoop_op == OP_RD || snoop_op == OP_RDX);
  assign snp_st     = snoop_next(cur_st, snoop_op);
  assign snp_we     = snp_hit && (snp_st != cur_st);

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NLINES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic              bus_req_valid,
  output logic [2:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_grant,
  input  logic              bus_shared_in,
  input  logic              snoop_valid,
  input  logic [2:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_shared,
  output logic              snoop_supply
);

  localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  mesi_t [NLINES-1:0]            line_st;
  logic  [NLINES-1:0][TAG_W-1:0] line_tag;

  logic              busy, resp_q, req_wr_q;
  logic [ADDR_W-1:0] req_addr_q;

  // Request being worked on: the incoming one when idle, the held one when busy.
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_wr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  mesi_t             cur_st;
  bus_op_t           need;

  assign cur_addr = busy ? req_addr_q : cpu_req_addr;
  assign cur_wr   = busy ? req_wr_q   : cpu_req_write;
  assign cur_idx  = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign cur_st   = line_st[cur_idx];
  assign need     = need_op(cur_st, line_tag[cur_idx] == cur_tag, cur_wr);

  // Named events
  logic accept, local_hit, silent_upgrade, fire, finish;
  assign cpu_req_ready  = !busy && !snoop_valid;
  assign accept         = cpu_req_valid && cpu_req_ready;
  assign local_hit      = accept && (need == OP_NONE);
  assign silent_upgrade = local_hit && cur_wr && (cur_st == ST_E);
  assign bus_req_valid  = busy && (need != OP_NONE);
  assign bus_req_op     = bus_req_valid ? need : OP_NONE;
  assign bus_req_addr   = (need == OP_WB) ? {line_tag[cur_idx], cur_idx} : cur_addr;
  assign fire           = bus_req_valid && bus_grant && !snoop_valid;
  assign finish         = busy && !snoop_valid && ((fire && need != OP_WB) || need == OP_NONE);

  // Local line update
  logic             loc_we;
  mesi_t            loc_st;
  logic [TAG_W-1:0] loc_tag;
  always_comb begin
    loc_we  = 1'b0;
    loc_st  = cur_st;
    loc_tag = cur_tag;
    if (silent_upgrade) begin
      loc_we = 1'b1;
      loc_st = ST_M;
    end else if (fire) begin
      loc_we = 1'b1;
      case (need)
        OP_WB:   begin loc_st = ST_I; loc_tag = line_tag[cur_idx]; end
        OP_RD:   loc_st = bus_shared_in ? ST_S : ST_E;
        default: loc_st = ST_M;
      endcase
    end
  end

  // Snoop side
  logic [IDX_W-1:0] snp_idx;
  logic             snp_hit, snp_we;
  mesi_t            snp_st;
  assign snp_idx = snoop_addr[IDX_W-1:0];

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid (snoop_valid),
    .snoop_op    (bus_op_t'(snoop_op)),
    .snoop_tag   (snoop_addr[ADDR_W-1:IDX_W]),
    .cur_st      (line_st[snp_idx]),
    .cur_tag     (line_tag[snp_idx]),
    .snp_hit     (snp_hit),
    .snp_supply  (snoop_supply),
    .snp_we      (snp_we),
    .snp_st      (snp_st)
  );
  assign snoop_shared = snp_hit;

  mesi_line_store #(.NLINES(NLINES), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .snp_we   (snp_we),
    .snp_idx  (snp_idx),
    .snp_st   (snp_st),
    .loc_we   (loc_we),
    .loc_idx  (cur_idx),
    .loc_st   (loc_st),
    .loc_tag  (loc_tag),
    .line_st  (line_st),
    .line_tag (line_tag)
  );

  // Request sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      resp_q     <= 1'b0;
      req_wr_q   <= 1'b0;
      req_addr_q <= '0;
    end else begin
      resp_q <= 1'b0;
      if (accept && need != OP_NONE) begin
        busy       <= 1'b1;
        req_addr_q <= cpu_req_addr;
        req_wr_q   <= cpu_req_write;
      end else if (local_hit) begin
        resp_q <= 1'b1;
      end
      if (finish) begin
        busy   <= 1'b0;
        resp_q <= 1'b1;
      end
    end
  end
  assign cpu_resp_valid = resp_q;

  // Assertions
  assert_rd_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need == OP_RD) |=>
      line_st[$past(cur_idx)] == ($past(bus_shared_in) ? ST_S : ST_E));

  assert_silent_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    silent_upgrade |=> (!bus_req_valid && line_st[$past(cur_idx)] == ST_M));

  assert_own_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (need == OP_UPGR || need == OP_RDX)) |=> line_st[$past(cur_idx)] == ST_M);

  assert_supply_implies_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_supply |-> snoop_shared);

  assert_snoop_read_demotes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && bus_op_t'(snoop_op) == OP_RD && line_st[snp_idx] != ST_S) |=>
      line_st[$past(snp_idx)] == ST_S);

  assert_snoop_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && (bus_op_t'(snoop_op) == OP_RDX || bus_op_t'(snoop_op) == OP_UPGR)) |=>
      line_st[$past(snp_idx)] == ST_I);

  assert_snoop_holds_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && busy) |=> busy);

  assert_victim_then_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need == OP_WB) |=> (line_st[$past(cur_idx)] == ST_I && bus_req_valid));

endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  localparam int AW = 8;
  localparam logic [2:0] RD = 3'd1, RDX = 3'd2, UPGR = 3'd3, WB = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req_valid = 0, cpu_req_write = 0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic cpu_req_ready, cpu_resp_valid, bus_req_valid;
  logic [2:0] bus_req_op;
  logic [AW-1:0] bus_req_addr;
  logic bus_grant = 0, bus_shared_in = 0;
  logic snoop_valid = 0;
  logic [2:0] snoop_op = '0;
  logic [AW-1:0] snoop_addr = '0;
  logic snoop_shared, snoop_supply;

  mesi_snoop_ctrl #(.ADDR_W(AW), .NLINES(4)) uut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic auto_grant = 1'b1;
  logic [AW+2:0] exp_q[$];
  string req_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_bus(string req, logic [2:0] op, logic [AW-1:0] a);
    exp_q.push_back({op, a});
    req_q.push_back(req);
  endtask

  // Monitor: grants requests and compares each performed transaction.
  always @(negedge clk) begin
    #2;
    bus_grant = auto_grant && bus_req_valid;
    if (bus_grant && !snoop_valid && rst_n) begin
      if (exp_q.size() == 0) check("unexpected bus op", {21'd0, bus_req_op, bus_req_addr}, 32'd0);
      else begin
        automatic logic [AW+2:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, {21'd0, bus_req_op, bus_req_addr}, {21'd0, e});
      end
    end
  end

  task automatic cpu_start(logic w, logic [AW-1:0] a);
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_write = w; cpu_req_addr = a;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cpu_req_valid = 0;
  endtask

  task automatic wait_resp(string req, int exp_wait);
    int n = 0;
    #1;
    while (!cpu_resp_valid && n < 50) begin @(negedge clk); #1; n++; end
    if (exp_wait >= 0) check(req, n, exp_wait);
    else check(req, n < 50, 1);
  endtask

  task automatic cpu_op(string req, logic w, logic [AW-1:0] a, int exp_wait);
    cpu_start(w, a);
    wait_resp(req, exp_wait);
  endtask

  task automatic snoop(string req, logic [2:0] op, logic [AW-1:0] a, logic sh, logic sup);
    @(negedge clk);
    snoop_valid = 1; snoop_op = op; snoop_addr = a;
    cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = 8'hFF;
    #1;
    check({req, " shared"}, snoop_shared, sh);
    check({req, " supply"}, snoop_supply, sup);
    check("R8 ready low under snoop", cpu_req_ready, 0);
    @(negedge clk);
    snoop_valid = 0; cpu_req_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 ready", cpu_req_ready, 1);
    check("R1 no bus request", bus_req_valid, 0);
    check("R1 no response", cpu_resp_valid, 0);
    snoop("R1 empty", RD, 8'h04, 0, 0);

    // R2 exclusive fill, R3 silent writes
    bus_shared_in = 0;
    expect_bus("R2 read miss", RD, 8'h04);
    cpu_op("R2 read miss done", 0, 8'h04, -1);
    cpu_op("R3 write E no bus", 1, 8'h04, 0);
    cpu_op("R3 write M no bus", 1, 8'h04, 0);
    snoop("R6 snoop read of M", RD, 8'h04, 1, 1);
    expect_bus("R4 invalidate from S", UPGR, 8'h04);
    cpu_op("R4 write S done", 1, 8'h04, -1);
    snoop("R6 M supplies again", RD, 8'h04, 1, 1);

    // R2 shared fill
    bus_shared_in = 1;
    expect_bus("R2 read miss shared", RD, 8'h09);
    cpu_op("R2 shared fill done", 0, 8'h09, -1);
    bus_shared_in = 0;
    expect_bus("R2 shared fill then invalidate", UPGR, 8'h09);
    cpu_op("R4 write shared line", 1, 8'h09, -1);

    // R7 invalidations
    snoop("R7 snoop rdx on M", RDX, 8'h09, 1, 1);
    expect_bus("R7 miss after rdx", RD, 8'h09);
    cpu_op("R7 reread", 0, 8'h09, -1);
    snoop("R7 snoop invalidate on E", UPGR, 8'h09, 1, 0);
    expect_bus("R7 miss after invalidate", RD, 8'h09);
    cpu_op("R7 reread 2", 0, 8'h09, -1);

    // R11 shared indication
    snoop("R11 tag mismatch", RD, 8'h0D, 0, 0);
    snoop("R11 hit on S", RD, 8'h04, 1, 0);

    // R5 write miss
    expect_bus("R5 write miss", RDX, 8'h0E);
    cpu_op("R5 write miss done", 1, 8'h0E, -1);
    snoop("R5 line is M", RD, 8'h0E, 1, 1);

    // R9 lost race: pending invalidate becomes read-for-ownership
    auto_grant = 0;
    expect_bus("R9 restarted write", RDX, 8'h04);
    cpu_start(1, 8'h04);
    #1;
    check("R9 pending op before race", bus_req_op, UPGR);
    snoop("R9 competing invalidate", UPGR, 8'h04, 1, 0);
    #1;
    check("R9 pending op after race", bus_req_op, RDX);
    auto_grant = 1;
    wait_resp("R9 restarted write done", -1);

    // R8 grant during snoop is ignored
    auto_grant = 0;
    expect_bus("R8 read performed once", RD, 8'h13);
    cpu_start(0, 8'h13);
    @(negedge clk);
    auto_grant = 1;
    snoop_valid = 1; snoop_op = RD; snoop_addr = 8'h20;
    #1;
    check("R8 no supply on miss", snoop_supply, 0);
    @(negedge clk);
    snoop_valid = 0;
    wait_resp("R8 read done", -1);

    // R10 dirty victim writeback then fill
    expect_bus("R10 victim writeback", WB, 8'h04);
    expect_bus("R10 fill after writeback", RD, 8'h20);
    cpu_op("R10 eviction read", 0, 8'h20, -1);
    expect_bus("R10 clean victim no writeback", RD, 8'h04);
    cpu_op("R10 clean eviction", 0, 8'h04, -1);

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule